// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This controller sits between a processor memory bus and a set of DRAM banks whose address pins are shared between a row phase and a column phase. It keeps a DRAM row open by holding the row strobe low between accesses. It also remembers which row is open. Each new request has its row field compared for equality against that stored row. When the row is already open, the access runs as a single column-strobe cycle and the processor is never stalled.

When the row field differs, or no row is open, the processor gets one stall cycle. During that cycle the controller lifts the row strobe to precharge, puts the new row on the multiplexed address lines and records it. On the next cycle it lowers the row strobe again together with the column strobe of the addressed bank. The row strobe goes to every bank together, so one open row is shared by all banks, and the bank field is not part of the comparison.

A refresh-taken input tells the controller that a refresh has used the row lines. The controller then closes the page and treats the next access as a miss. The controller does not drive the data bus and does not generate refresh.

Top module: `pgdram_ctrl`

## Requirements
- R1: After reset, every row strobe and every column strobe is high, the write strobe is high and no row is open. With the request low, the stall output is low.
- R2: The address is laid out as {bank, row, column}, with the column in bits [COL_W-1:0], the row in the next ROW_W bits and the bank in the top BANK_W bits. If a row is open and the request's row field equals it, the stall output stays low and the access is accepted at the next edge.
- R3: If no row is open, or the row field differs from the open row, the stall output is high in that same cycle for exactly one cycle. In the following cycle all row strobes are high and the multiplexed address carries the new row.
- R4: In the cycle after an access is accepted, all row strobes are low, the addressed bank's column strobe is low and the multiplexed address carries the column field.
- R5: While a row is open and no access is running, all row strobes stay low and all column strobes stay high.
- R6: Reads and writes take the same cycles. The write strobe is low during the column cycle of a write and high at every other time.
- R7: A refresh-taken pulse closes the page, so all row strobes are high in the next cycle, and the next access is a miss.
- R8: At most one column strobe is low at a time, and it is the bank selected by the bank field. The bank field has no effect on hit or miss: the same row in another bank hits.
- R9: A request that coincides with refresh-taken is stalled and not accepted in that cycle.
- R10: Over any sequence of accesses, the number of stall cycles equals the number of row changes plus the number of accesses that are the first after reset or after a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Memory request, held until accepted |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | BANK_W+ROW_W+COL_W | Processor address {bank, row, column} |
| refresh_i | input | 1 | A refresh used the row lines this cycle |
| wait_o | output | 1 | Stall to the processor |
| ras_n_o | output | 2**BANK_W | Row strobes, active low, one per bank |
| cas_n_o | output | 2**BANK_W | Column strobes, active low, one per bank |
| we_n_o | output | 1 | DRAM write strobe, active low |
| ma_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |

## Verification
The assertions check on every cycle the relationships that hold between neighbouring cycles:
- a column strobe is low only together with the row strobes and only for one bank;
- a stall is followed by the precharge and row phase, and lasts a single cycle;
- the row phase leads into the column cycle;
- refresh closes the page;
- the write strobe appears only inside a column cycle.

Only the bench's scenarios can show the behaviours that depend on history. These are whether a request hits or misses given the rows visited earlier, that another bank's identical row still hits, that a request colliding with refresh is held off, and that the total number of stall cycles over a long mixed sequence matches the count of row changes plus accesses after a refresh.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_CAS  = 2'd2
    } phase_e;
endpackage

// File: rtl/pgdram_row_cmp.sv
module pgdram_row_cmp #(
    parameter int ROW_W = 7
) (
    input  logic [ROW_W-1:0] row_new_i,
    input  logic [ROW_W-1:0] row_open_i,
    input  logic             open_valid_i,
    output logic             hit_o
);
    logic [ROW_W-1:0] diff;

    // Equality only: one XOR per bit, then a single OR reduction.
    for (genvar i = 0; i < ROW_W; i++) begin : g_bit
        assign diff[i] = row_new_i[i] ^ row_open_i[i];
    end

    assign hit_o = open_valid_i & ~(|diff);
endmodule

// File: rtl/pgdram_addr_mux.sv
module pgdram_addr_mux #(
    parameter int ROW_W = 7,
    parameter int COL_W = 7,
    parameter int MA_W  = 7
) (
    input  logic             sel_col_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [COL_W-1:0] col_i,
    output logic [MA_W-1:0]  ma_o
);
    always_comb begin
        ma_o = '0;
        if (sel_col_i) ma_o[COL_W-1:0] = col_i;
        else           ma_o[ROW_W-1:0] = row_i;
    end
endmodule

// File: rtl/pgdram_bank_dec.sv
module pgdram_bank_dec #(
    parameter int BANK_W = 2,
    localparam int BANKS = 1 << BANK_W
) (
    input  logic [BANK_W-1:0] bank_i,
    output logic [BANKS-1:0]  strobe_n_o
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign strobe_n_o[b] = ~(bank_i == BANK_W'(b));
    end
endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
    import pgdram_pkg::*;
#(
    parameter int ROW_W  = 7,
    parameter int COL_W  = 7,
    parameter int BANK_W = 2
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            req_i,
    input  logic                            we_i,
    input  logic [BANK_W+ROW_W+COL_W-1:0]   addr_i,
    input  logic                            refresh_i,
    output logic                            wait_o,
    output logic [(1<<BANK_W)-1:0]          ras_n_o,
    output logic [(1<<BANK_W)-1:0]          cas_n_o,
    output logic                            we_n_o,
    output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] ma_o
);
    localparam int BANKS = 1 << BANK_W;
    localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

    typedef struct packed {
        phase_e            phase;
        logic              valid;
        logic [ROW_W-1:0]  row;
        logic              ras_n;
        logic [BANKS-1:0]  cas_n;
        logic              we_n;
        logic [MA_W-1:0]   ma;
    } regs_t;

    regs_t r_q, r_d;

    logic [ROW_W-1:0]  row_in;
    logic [COL_W-1:0]  col_in;
    logic [BANK_W-1:0] bank_in;
    logic              page_hit;
    logic              accept;
    logic              sel_col;
    logic [MA_W-1:0]   ma_next;
    logic [BANKS-1:0]  cas_sel_n;

    assign col_in  = addr_i[COL_W-1:0];
    assign row_in  = addr_i[COL_W +: ROW_W];
    assign bank_in = addr_i[COL_W+ROW_W +: BANK_W];

    pgdram_row_cmp #(.ROW_W(ROW_W)) u_cmp (
        .row_new_i   (row_in),
        .row_open_i  (r_q.row),
        .open_valid_i(r_q.valid),
        .hit_o       (page_hit)
    );

    pgdram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_mux (
        .sel_col_i(sel_col),
        .row_i    (row_in),
        .col_i    (col_in),
        .ma_o     (ma_next)
    );

    pgdram_bank_dec #(.BANK_W(BANK_W)) u_dec (
        .bank_i    (bank_in),
        .strobe_n_o(cas_sel_n)
    );

    // Stall in the very cycle a miss (or a refresh collision) is seen.
    assign wait_o = req_i & (refresh_i | ~page_hit);
    assign accept = req_i & ~wait_o;
    assign sel_col = ~wait_o;

    always_comb begin
        r_d       = r_q;
        r_d.cas_n = '1;
        r_d.we_n  = 1'b1;
        r_d.ras_n = ~r_q.valid;
        r_d.phase = ST_IDLE;
        if (refresh_i) begin
            r_d.valid = 1'b0;
            r_d.ras_n = 1'b1;
        end else if (accept) begin
            r_d.phase = ST_CAS;
            r_d.ras_n = 1'b0;
            r_d.cas_n = cas_sel_n;
            r_d.we_n  = ~we_i;
            r_d.ma    = ma_next;
        end else if (wait_o) begin
            r_d.phase = ST_ROW;
            r_d.ras_n = 1'b1;
            r_d.valid = 1'b1;
            r_d.row   = row_in;
            r_d.ma    = ma_next;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{phase: ST_IDLE, valid: 1'b0, row: '0, ras_n: 1'b1,
                     cas_n: '1, we_n: 1'b1, ma: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ras_n_o = {BANKS{r_q.ras_n}};
    assign cas_n_o = r_q.cas_n;
    assign we_n_o  = r_q.we_n;
    assign ma_o    = r_q.ma;

    p_cas_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~cas_n_o));

    p_cas_under_ras_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(&cas_n_o) |-> (ras_n_o == '0));

    p_miss_rowphase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wait_o && !refresh_i) |=>
            (ras_n_o == '1) && (ma_o[ROW_W-1:0] == $past(addr_i[COL_W +: ROW_W])));

    p_wait_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wait_o && !refresh_i) |=> (!wait_o || refresh_i));

    p_row_to_cas_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.phase == ST_ROW && req_i && !refresh_i) |=>
            (ras_n_o == '0) && !(&cas_n_o));

    p_refresh_close_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refresh_i |=> (ras_n_o == '1));

    p_we_in_cas_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_n_o |-> !(&cas_n_o));
endmodule

// File: tb/pgdram_ctrl_bench.sv
module pgdram_ctrl_bench;
    localparam int ROW_W = 7, COL_W = 7, BANK_W = 2;
    localparam int AW = BANK_W + ROW_W + COL_W;
    localparam int BANKS = 1 << BANK_W;

    logic clk = 0, rst_n = 0, req = 0, we = 0, refresh = 0;
    logic [AW-1:0] addr = '0;
    logic wait_o, we_n_o;
    logic [BANKS-1:0] ras_n_o, cas_n_o;
    logic [ROW_W-1:0] ma_o;

    int checks = 0, errors = 0;
    bit m_valid = 0;
    logic [ROW_W-1:0] m_row = '0;
    int total_waits = 0, n_rowchg = 0, n_after = 0;

    always #2 clk = ~clk;

    pgdram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_pgdram_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .refresh_i(refresh), .wait_o(wait_o), .ras_n_o(ras_n_o),
        .cas_n_o(cas_n_o), .we_n_o(we_n_o), .ma_o(ma_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_miss(input bit v, input logic [ROW_W-1:0] r,
                                    input logic [AW-1:0] a);
        return !v || (a[COL_W +: ROW_W] != r);
    endfunction

    function automatic logic [BANKS-1:0] exp_cas(input logic [AW-1:0] a);
        return ~(BANKS'(1) << a[COL_W+ROW_W +: BANK_W]);
    endfunction

    // Called just after a falling edge; returns just after a falling edge.
    task automatic do_access(input logic [AW-1:0] a, input bit w);
        bit miss;
        bit wt;
        int waits;
        miss = exp_miss(m_valid, m_row, a);
        waits = 0;
        req = 1; addr = a; we = w;
        forever begin
            #1; wt = wait_o;
            @(posedge clk); @(negedge clk);
            if (!wt) break;
            waits++;
            chk(ras_n_o == '1 && ma_o == a[COL_W +: ROW_W], "R3 row phase",
                int'(ma_o), int'(a[COL_W +: ROW_W]));
            if (waits > 3) break;
        end
        chk(waits == int'(miss), miss ? "R3 miss stall" : "R2 hit no stall",
            waits, int'(miss));
        chk(cas_n_o == exp_cas(a), "R8 bank cas", int'(cas_n_o), int'(exp_cas(a)));
        chk(ras_n_o == '0, "R4 ras in cas cycle", int'(ras_n_o), 0);
        chk(ma_o == a[COL_W-1:0], "R4 column addr", int'(ma_o), int'(a[COL_W-1:0]));
        chk(we_n_o == !w, "R6 write strobe", int'(we_n_o), int'(!w));
        req = 0;
        if (!m_valid) n_after++;
        else if (miss) n_rowchg++;
        total_waits += waits;
        m_valid = 1;
        m_row = a[COL_W +: ROW_W];
    endtask

    task automatic do_refresh();
        refresh = 1;
        @(posedge clk); @(negedge clk);
        refresh = 0;
        chk(ras_n_o == '1, "R7 page closed", int'(ras_n_o), int'({BANKS{1'b1}}));
        m_valid = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_0a11));
        repeat (3) @(negedge clk);
        chk(ras_n_o == '1 && cas_n_o == '1, "R1 strobes in reset",
            int'({ras_n_o, cas_n_o}), 8'hff);
        rst_n = 1;
        @(negedge clk);
        chk(we_n_o == 1 && wait_o == 0, "R1 idle after reset",
            int'({we_n_o, wait_o}), 2);
        chk(ras_n_o == '1, "R1 no open row", int'(ras_n_o), 15);

        // Directed: first access misses, then same row hits (R1, R2).
        do_access({2'd0, 7'h05, 7'h10}, 0);
        do_access({2'd0, 7'h05, 7'h11}, 1);
        // Same row, other bank still hits (R8).
        do_access({2'd3, 7'h05, 7'h7f}, 0);
        // Idle with page open (R5).
        @(posedge clk); @(negedge clk);
        chk(ras_n_o == '0 && cas_n_o == '1, "R5 page held open",
            int'({ras_n_o, cas_n_o}), 4'hf);
        // Row change (R3), then write timing (R6).
        do_access({2'd1, 7'h06, 7'h00}, 1);
        // Refresh forces next access to miss (R7).
        do_refresh();
        do_access({2'd1, 7'h06, 7'h01}, 0);
        // Refresh colliding with a request (R9).
        req = 1; addr = {2'd2, 7'h06, 7'h02}; we = 0; refresh = 1;
        #1;
        chk(wait_o == 1, "R9 stall on refresh", int'(wait_o), 1);
        @(posedge clk); @(negedge clk);
        refresh = 0;
        chk(cas_n_o == '1, "R9 not accepted", int'(cas_n_o), 15);
        m_valid = 0;
        do_access({2'd2, 7'h06, 7'h02}, 0);

        // Constrained random mix.
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [ROW_W-1:0] r;
            op = int'($urandom % 16);
            if (op == 0) begin
                do_refresh();
            end else begin
                r = (op < 11 && m_valid) ? m_row : ROW_W'($urandom % 8);
                do_access({BANK_W'($urandom), r, COL_W'($urandom)}, 1'($urandom));
            end
        end

        chk(total_waits == n_rowchg + n_after, "R10 stall count",
            total_waits, n_rowchg + n_after);
        summary();
    end
endmodule